// File: doc/BRIEF.md
# Unit-Stride Element Displacement Generator

For each element of a vectorised memory access, this block works out the immediate displacement that the access should use. It takes the raw immediate field of the instruction and decodes it in one of two ways. In the 16-bit form, the field is sign-extended. In the scaled 14-bit form, the field is multiplied by four and then sign-extended. When the unit-stride addressing mode is active, the block adds a per-element offset to the decoded immediate. That offset is a flat element index multiplied by the access width in bytes.

The flat element index comes from an element step and a sub-element step, with the step weighted by the sub-vector length. A load draws on the source-side steps and a store draws on the destination-side steps. Any other operation contributes an index of zero. A replace flag tells the downstream pipeline that the computed value should override the instruction's own immediate. This flag is raised only in unit-stride mode.

The result is registered, so it appears with one cycle of latency and a valid strobe. Adding the base register is left to the consumer, and so are remapped indices.

Top module: `ustride_disp_gen`

## Requirements
- R1: While reset is asserted (rst_n low), out_valid, disp and replace are all 0.
- R2: out_valid equals in_valid of the previous cycle. In a cycle after in_valid was low, disp and replace keep their previous values.
- R3: With fmt_scaled=0, the decoded immediate is imm_field[15:0] sign-extended to 32 bits.
- R4: With fmt_scaled=1, the decoded immediate is {imm_field[13:0], 2'b00} sign-extended from bit 15 to 32 bits. Bits 15:14 of imm_field are ignored.
- R5: The element index is step * (sub_len + 1) + sub. Here sub_len holds the sub-vector length minus one (0 to 3).
- R6: When op_kind=2'b01 (load), the index uses src_step and src_sub. When op_kind=2'b10 (store), it uses dst_step and dst_sub.
- R7: When op_kind is 2'b00 or 2'b11, the element index is 0, so disp equals the decoded immediate.
- R8: With stride_en=1, disp = decoded immediate + index * (1 << width_sel), taken modulo 2^32. width_sel 0/1/2/3 selects 1/2/4/8 bytes.
- R9: replace equals the stride_en sampled with the accepted request. With stride_en=0, disp is the decoded immediate alone, whatever the steps are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| imm_field | input | 16 | Raw immediate field of the instruction |
| fmt_scaled | input | 1 | 1 selects the scaled 14-bit form, 0 selects the 16-bit form |
| op_kind | input | 2 | 01 load, 10 store, 00/11 other |
| stride_en | input | 1 | Unit-stride mode active |
| src_step | input | 7 | Source element step |
| src_sub | input | 2 | Source sub-element step |
| dst_step | input | 7 | Destination element step |
| dst_sub | input | 2 | Destination sub-element step |
| sub_len | input | 2 | Sub-vector length minus one |
| width_sel | input | 2 | Access width code (log2 of bytes) |
| out_valid | output | 1 | Registered result valid |
| disp | output | 32 | Registered displacement |
| replace | output | 1 | Registered override flag |

## Verification
Scaled-form decoding and stride addition can act in the same cycle. In that case a negative scaled immediate must be combined with a large positive element offset, and the sum may cross zero or wrap at 32 bits. Directed vectors are used to provoke this. They pair the most negative scaled field with the largest step, sub-step and width, and also pair small negative fields with offsets that just cancel them. Random traffic then mixes both forms with every operation kind. Each registered result is judged against a behavioural integer model, which applies sign extension, scaling, index selection and truncation on its own arithmetic.

// File: rtl/ustride_disp_gen.sv
module ustride_disp_gen #(
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2,
  parameter int IMM_W  = 16,
  parameter int SC_W   = 14,
  parameter int OUT_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IMM_W-1:0] imm_field,
  input  logic             fmt_scaled,
  input  logic [1:0]       op_kind,
  input  logic             stride_en,
  input  logic [STEP_W-1:0] src_step,
  input  logic [SUB_W-1:0] src_sub,
  input  logic [STEP_W-1:0] dst_step,
  input  logic [SUB_W-1:0] dst_sub,
  input  logic [SUB_W-1:0] sub_len,
  input  logic [1:0]       width_sel,
  output logic             out_valid,
  output logic [OUT_W-1:0] disp,
  output logic             replace
);
  localparam int IDX_W = STEP_W + SUB_W + 1;

  logic [OUT_W-1:0]  imm_d, imm_s, imm_dec, ofs;
  logic [STEP_W-1:0] step_sel;
  logic [SUB_W-1:0]  sub_sel;
  logic [IDX_W-1:0]  elem_idx;
  logic              is_ld, is_st;

  assign imm_d   = {{(OUT_W-IMM_W){imm_field[IMM_W-1]}}, imm_field};
  assign imm_s   = {{(OUT_W-SC_W-2){imm_field[SC_W-1]}}, imm_field[SC_W-1:0], 2'b00};
  assign imm_dec = fmt_scaled ? imm_s : imm_d;

  assign is_ld    = (op_kind == 2'b01);
  assign is_st    = (op_kind == 2'b10);
  assign step_sel = is_ld ? src_step : (is_st ? dst_step : '0);
  assign sub_sel  = is_ld ? src_sub  : (is_st ? dst_sub  : '0);

  assign elem_idx = IDX_W'(step_sel) * (IDX_W'(sub_len) + IDX_W'(1)) + IDX_W'(sub_sel);
  assign ofs      = stride_en ? (OUT_W'(elem_idx) << width_sel) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      disp      <= '0;
      replace   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        disp    <= imm_dec + ofs;
        replace <= stride_en;
      end
    end
  end
endmodule

// File: rtl/ustride_disp_gen_chk.sv
module ustride_disp_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [15:0] imm_field,
  input logic        fmt_scaled,
  input logic [1:0]  op_kind,
  input logic        stride_en,
  input logic        out_valid,
  input logic [31:0] disp,
  input logic        replace
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (!out_valid && !replace && disp == 32'd0);
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(disp) && $stable(replace)));

  a_r9_flag_tracks_mode: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> replace == $past(stride_en));

  a_r3_plain_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !stride_en && !fmt_scaled) |=>
      disp == {{16{$past(imm_field[15])}}, $past(imm_field)});

  a_r4_scaled_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !stride_en && fmt_scaled) |=> disp[1:0] == 2'b00);

  a_r7_other_op_no_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !fmt_scaled && (op_kind == 2'b00 || op_kind == 2'b11)) |=>
      disp == {{16{$past(imm_field[15])}}, $past(imm_field)});
endmodule

bind ustride_disp_gen ustride_disp_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .imm_field(imm_field),
  .fmt_scaled(fmt_scaled), .op_kind(op_kind), .stride_en(stride_en),
  .out_valid(out_valid), .disp(disp), .replace(replace)
);

// File: tb/sim_ustride_disp_gen.sv
`timescale 1ns/1ps
module sim_ustride_disp_gen;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, fmt_scaled = 0, stride_en = 0;
  logic [15:0] imm_field = 0;
  logic [1:0]  op_kind = 0, width_sel = 0, src_sub = 0, dst_sub = 0, sub_len = 0;
  logic [6:0]  src_step = 0, dst_step = 0;
  logic        out_valid, replace;
  logic [31:0] disp;

  always #5 clk = ~clk;

  ustride_disp_gen u0 (.*);

  int vectors = 0, miscompares = 0;
  bit done = 0;
  bit          e_valid = 0, e_rep = 0;
  logic [31:0] e_disp = 0;
  string       e_tag = "R1";

  function automatic logic [31:0] model(input logic [15:0] imm, input bit sc,
      input logic [1:0] op, input bit st, input int ss, input int sd, input int ds,
      input int dd, input int sl, input int wsel);
    longint base, idx;
    if (sc) begin
      base = imm[13:0];
      if (base >= 8192) base -= 16384;
      base *= 4;
    end else begin
      base = imm;
      if (base >= 32768) base -= 65536;
    end
    if (op == 2'b01) idx = ss * (sl + 1) + ds;
    else if (op == 2'b10) idx = sd * (sl + 1) + dd;
    else idx = 0;
    if (st) base += idx * (longint'(1) << wsel);
    return base[31:0];
  endfunction

  task automatic compare();
    vectors++;
    if (out_valid !== e_valid || replace !== e_rep || disp !== e_disp) begin
      miscompares++;
      $display("FAIL %s: got v=%0b r=%0b d=%h expected v=%0b r=%0b d=%h",
               e_tag, out_valid, replace, disp, e_valid, e_rep, e_disp);
    end
  endtask

  task automatic apply(input bit v, input logic [15:0] imm, input bit sc,
      input logic [1:0] op, input bit st, input int ss, input int sd,
      input int ds, input int dd, input int sl, input int wsel);
    @(negedge clk);
    compare();
    in_valid = v; imm_field = imm; fmt_scaled = sc; op_kind = op; stride_en = st;
    src_step = 7'(ss); dst_step = 7'(sd); src_sub = 2'(ds); dst_sub = 2'(dd);
    sub_len = 2'(sl); width_sel = 2'(wsel);
    e_valid = v;
    if (v) begin
      e_rep  = st;
      e_disp = model(imm, sc, op, st, ss, sd, ds, dd, sl, wsel);
      if (!st) e_tag = sc ? "R4/R9" : "R3/R9";
      else if (op == 2'b00 || op == 2'b11) e_tag = "R7";
      else if (op == 2'b01) e_tag = "R6-load/R8";
      else e_tag = "R6-store/R5";
    end else e_tag = "R2";
  endtask

  initial begin
    repeat (3) begin @(negedge clk); compare(); end   // R1 reset state
    rst_n = 1;
    // R3 negative and positive plain immediates, steps ignored without stride
    apply(1, 16'h8000, 0, 2'b01, 0, 100, 5, 3, 2, 3, 3);
    apply(1, 16'h7fff, 0, 2'b10, 0, 1, 127, 0, 3, 0, 2);
    // R4 scaled form, high bits ignored
    apply(1, 16'hE000, 1, 2'b01, 0, 9, 9, 1, 1, 1, 1);
    apply(1, 16'h1fff, 1, 2'b00, 0, 0, 0, 0, 0, 0, 0);
    // R2 idle cycles hold
    apply(0, 16'h1234, 0, 2'b01, 1, 5, 5, 1, 1, 1, 1);
    apply(0, 16'h0000, 1, 2'b10, 1, 7, 7, 0, 0, 0, 0);
    // R5/R6 load vs store with distinct src/dst
    apply(1, 16'h0010, 0, 2'b01, 1, 3, 50, 2, 1, 3, 2);
    apply(1, 16'h0010, 0, 2'b10, 1, 3, 50, 2, 1, 3, 2);
    // R7 other ops
    apply(1, 16'hfff0, 0, 2'b00, 1, 127, 127, 3, 3, 3, 3);
    apply(1, 16'hfff0, 0, 2'b11, 1, 127, 127, 3, 3, 3, 3);
    // R8 scaled negative + maximal offset, and exact cancellation
    apply(1, 16'h2000, 1, 2'b01, 1, 127, 0, 3, 0, 3, 3);
    apply(1, 16'h3fff, 1, 2'b10, 1, 0, 1, 0, 0, 0, 2);
    apply(1, 16'hfffc, 0, 2'b01, 1, 1, 0, 0, 0, 0, 2);
    for (int i = 0; i < 3000; i++)
      apply($urandom_range(0, 5) != 0, 16'($urandom), 1'($urandom), 2'($urandom),
            1'($urandom), $urandom_range(0, 127), $urandom_range(0, 127),
            $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
            $urandom_range(0, 3));
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); compare();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule